// File: doc/BRIEF.md
# Symbol Pair Decoder and Line State Tracker

This block takes a receive stream that has already been aligned into pairs of 5-bit code groups. Each accepted pair is translated into two 4-bit values. Each value carries a control marker and a violation marker. The decoded pair is presented on an output stream. The sequence of pairs also drives a line state tracker. The tracker reports the current condition of the link as a 4-bit code, and it keeps one sticky flag per state. A flag sets when its state is entered, and software clears the flags with a one-cycle pulse.

Both stream edges use valid/ready. A pair is taken on any clock edge where `in_valid` and `in_ready` are both high. The result appears on the output stream on the next cycle. It stays there unchanged, with `out_valid` high, until a cycle in which `out_ready` is high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. This gives full throughput when the consumer never stalls, and zero extra storage when it does. The state code and the sticky flags are plain status pins. They change only on the edge that takes a pair, except that a clear pulse alone also acts on the flags.

Top module: `symbol_pair_rx`

## Requirements
- R1: Data code groups decode with the control and violation markers low: 11110→0, 01001→1, 10100→2, 10101→3, 01010→4, 01011→5, 01110→6, 01111→7, 10010→8, 10011→9, 10110→A, 10111→B, 11010→C, 11011→D, 11100→E, 11101→F.
- R2: Control code groups decode with the control marker high and the violation marker low: 11111 (idle)→A, 00100 (halt)→1, 11000 (J)→D, 10001 (K)→D, 01101 (T)→5, 00111 (R)→6, 11001 (S)→7, 00000 (quiet)→2.
- R3: Any other code group decodes to 2 with both the control marker and the violation marker high. Bit 0 of `out_ctl`/`out_viol` belongs to `in_sym0`/`out_nib0`, and bit 1 belongs to the second symbol.
- R4: A pair of J then K puts `line_state` to 2 (active) from any state. While the state is active, a pair made only of data, T, R or S symbols keeps it at 2.
- R5: A pair that meets no entry or hold condition sets `line_state` to 1 (unknown). This includes a lone idle pair and any other control or violation symbol while active. The code after reset is 0 and is never re-entered.
- R6: Two consecutive idle-idle pairs give code 3 (idle). Eight or more consecutive idle-idle pairs give code 4 (super idle).
- R7: Eight consecutive quiet-quiet pairs give code 5. Eight consecutive halt-halt pairs give code 6. Eight consecutive halt-then-quiet pairs give code 7. Each run count saturates, so the state holds while the run continues. A pair that breaks a run restarts that run from zero.
- R8: Four consecutive pairs that each hold at least one violation symbol give code 8 (noise).
- R9: `cond_flags[k]` sets on the accepting edge where `line_state` changes to code k. It is cleared only by `flags_clr`. When a set and a clear fall on the same edge, the set bit ends high and all other bits end low.
- R10: A pair is taken only when `in_valid && in_ready`, and `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, every output stream signal holds its value. `line_state` changes only on an accepting edge.
- R11: After reset, `out_valid` is 0, `in_ready` is 1, `line_state` is 0 and `cond_flags` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pair present |
| in_ready | output | 1 | Block can take a pair this cycle |
| in_sym0 | input | 5 | First code group of the pair |
| in_sym1 | input | 5 | Second code group of the pair |
| out_valid | output | 1 | Decoded pair present |
| out_ready | input | 1 | Consumer takes the decoded pair |
| out_nib0 | output | 4 | Decoded value of the first symbol |
| out_nib1 | output | 4 | Decoded value of the second symbol |
| out_ctl | output | 2 | Control markers, bit 0 for first symbol |
| out_viol | output | 2 | Violation markers, bit 0 for first symbol |
| line_state | output | 4 | Current line state code |
| cond_flags | output | 9 | Sticky entry flags, bit k for state code k |
| flags_clr | input | 1 | One-cycle clear of all sticky flags |

## Verification
A flag set and a flag clear can land on the same edge. The bench provokes this by raising `flags_clr` in the very cycle a J-K pair is accepted, after earlier states have already set several flags. The scoreboard expects only the active bit to remain. A second collision happens between output back-pressure and acceptance. Here `out_ready` is toggled by a pattern that is independent of the driver, so pairs queue behind a stalled output. Each decoded item is then compared, together with the line state that it produced, exactly once when it leaves.

// File: rtl/lsd_pkg.sv
package lsd_pkg;

  typedef enum logic [3:0] {
    SK_DATA  = 4'd0,
    SK_IDLE  = 4'd1,
    SK_HALT  = 4'd2,
    SK_QUIET = 4'd3,
    SK_J     = 4'd4,
    SK_K     = 4'd5,
    SK_T     = 4'd6,
    SK_R     = 4'd7,
    SK_S     = 4'd8,
    SK_VIOL  = 4'd9
  } skind_e;

  typedef enum logic [3:0] {
    LS_INIT    = 4'd0,
    LS_UNKNOWN = 4'd1,
    LS_ACTIVE  = 4'd2,
    LS_IDLE    = 4'd3,
    LS_SUPER   = 4'd4,
    LS_QUIET   = 4'd5,
    LS_HALT    = 4'd6,
    LS_HQ      = 4'd7,
    LS_NOISE   = 4'd8
  } lstate_e;

  localparam int NUM_LS = 9;

  typedef struct packed {
    logic [3:0] nib;
    logic       ctl;
    logic       viol;
    skind_e     kind;
  } dsym_t;

  function automatic dsym_t mk_sym(input logic [3:0] n, input skind_e k);
    dsym_t d;
    d.nib  = n;
    d.kind = k;
    d.ctl  = (k != SK_DATA);
    d.viol = (k == SK_VIOL);
    return d;
  endfunction

endpackage

// File: rtl/sym5_decode.sv
module sym5_decode
  import lsd_pkg::*;
(
  input  logic [4:0] code,
  output dsym_t      dec
);

  always_comb begin
    case (code)
      5'b11110: dec = mk_sym(4'h0, SK_DATA);
      5'b01001: dec = mk_sym(4'h1, SK_DATA);
      5'b10100: dec = mk_sym(4'h2, SK_DATA);
      5'b10101: dec = mk_sym(4'h3, SK_DATA);
      5'b01010: dec = mk_sym(4'h4, SK_DATA);
      5'b01011: dec = mk_sym(4'h5, SK_DATA);
      5'b01110: dec = mk_sym(4'h6, SK_DATA);
      5'b01111: dec = mk_sym(4'h7, SK_DATA);
      5'b10010: dec = mk_sym(4'h8, SK_DATA);
      5'b10011: dec = mk_sym(4'h9, SK_DATA);
      5'b10110: dec = mk_sym(4'hA, SK_DATA);
      5'b10111: dec = mk_sym(4'hB, SK_DATA);
      5'b11010: dec = mk_sym(4'hC, SK_DATA);
      5'b11011: dec = mk_sym(4'hD, SK_DATA);
      5'b11100: dec = mk_sym(4'hE, SK_DATA);
      5'b11101: dec = mk_sym(4'hF, SK_DATA);
      5'b11111: dec = mk_sym(4'hA, SK_IDLE);
      5'b00100: dec = mk_sym(4'h1, SK_HALT);
      5'b11000: dec = mk_sym(4'hD, SK_J);
      5'b10001: dec = mk_sym(4'hD, SK_K);
      5'b01101: dec = mk_sym(4'h5, SK_T);
      5'b00111: dec = mk_sym(4'h6, SK_R);
      5'b11001: dec = mk_sym(4'h7, SK_S);
      5'b00000: dec = mk_sym(4'h2, SK_QUIET);
      default:  dec = mk_sym(4'h2, SK_VIOL);
    endcase
  end

endmodule

// File: rtl/run_counter.sv
module run_counter #(
  parameter int LIMIT = 8,
  localparam int W = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         match,
  output logic [W-1:0] cnt,
  output logic [W-1:0] nxt
);

  always_comb begin
    if (!match)                nxt = '0;
    else if (cnt == W'(LIMIT)) nxt = cnt;
    else                       nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (adv) cnt <= nxt;
  end

  // R7
  cnt_saturates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= W'(LIMIT));

  // R7
  run_break_chk: assert property (@(posedge clk) disable iff (!rst_n)
    adv && !match |=> cnt == '0);

endmodule

// File: rtl/line_state_tracker.sv
module line_state_tracker
  import lsd_pkg::*;
#(
  parameter int IDLE_PAIRS  = 2,
  parameter int SUPER_PAIRS = 8,
  parameter int RUN_PAIRS   = 8,
  parameter int NOISE_PAIRS = 4
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    acc,
  input  skind_e  k0,
  input  skind_e  k1,
  output lstate_e st,
  output lstate_e nxt,
  output logic    entered
);

  localparam int IW = $clog2(SUPER_PAIRS + 1);
  localparam int RW = $clog2(RUN_PAIRS + 1);
  localparam int NW = $clog2(NOISE_PAIRS + 1);

  logic is_jk, ok0, ok1;
  logic m_idle, m_quiet, m_halt, m_hq, m_viol;
  logic [IW-1:0] idle_c, idle_n;
  logic [RW-1:0] q_c, q_n, h_c, h_n, hq_c, hq_n;
  logic [NW-1:0] v_c, v_n;

  assign is_jk   = (k0 == SK_J) && (k1 == SK_K);
  assign ok0     = k0 inside {SK_DATA, SK_T, SK_R, SK_S};
  assign ok1     = k1 inside {SK_DATA, SK_T, SK_R, SK_S};
  assign m_idle  = (k0 == SK_IDLE)  && (k1 == SK_IDLE);
  assign m_quiet = (k0 == SK_QUIET) && (k1 == SK_QUIET);
  assign m_halt  = (k0 == SK_HALT)  && (k1 == SK_HALT);
  assign m_hq    = (k0 == SK_HALT)  && (k1 == SK_QUIET);
  assign m_viol  = (k0 == SK_VIOL)  || (k1 == SK_VIOL);

  run_counter #(.LIMIT(SUPER_PAIRS)) u_idle_run (
    .clk(clk), .rst_n(rst_n), .adv(acc), .match(m_idle), .cnt(idle_c), .nxt(idle_n));
  run_counter #(.LIMIT(RUN_PAIRS)) u_quiet_run (
    .clk(clk), .rst_n(rst_n), .adv(acc), .match(m_quiet), .cnt(q_c), .nxt(q_n));
  run_counter #(.LIMIT(RUN_PAIRS)) u_halt_run (
    .clk(clk), .rst_n(rst_n), .adv(acc), .match(m_halt), .cnt(h_c), .nxt(h_n));
  run_counter #(.LIMIT(RUN_PAIRS)) u_hq_run (
    .clk(clk), .rst_n(rst_n), .adv(acc), .match(m_hq), .cnt(hq_c), .nxt(hq_n));
  run_counter #(.LIMIT(NOISE_PAIRS)) u_noise_run (
    .clk(clk), .rst_n(rst_n), .adv(acc), .match(m_viol), .cnt(v_c), .nxt(v_n));

  always_comb begin
    if (is_jk)                                nxt = LS_ACTIVE;
    else if (st == LS_ACTIVE && ok0 && ok1)   nxt = LS_ACTIVE;
    else if (idle_n >= IW'(SUPER_PAIRS))      nxt = LS_SUPER;
    else if (idle_n >= IW'(IDLE_PAIRS))       nxt = LS_IDLE;
    else if (q_n  == RW'(RUN_PAIRS))          nxt = LS_QUIET;
    else if (h_n  == RW'(RUN_PAIRS))          nxt = LS_HALT;
    else if (hq_n == RW'(RUN_PAIRS))          nxt = LS_HQ;
    else if (v_n  == NW'(NOISE_PAIRS))        nxt = LS_NOISE;
    else                                      nxt = LS_UNKNOWN;
  end

  assign entered = acc && (nxt != st);

  always_ff @(posedge clk) begin
    if (!rst_n)   st <= LS_INIT;
    else if (acc) st <= nxt;
  end

  // R4
  jk_enters_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc && is_jk |=> st == LS_ACTIVE);

  // R10
  state_only_on_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(st));

  // R6
  super_idle_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == LS_SUPER |-> idle_c == IW'(SUPER_PAIRS));

  // R8
  noise_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == LS_NOISE |-> v_c == NW'(NOISE_PAIRS));

endmodule

// File: rtl/sticky_flags.sv
module sticky_flags #(
  parameter int N = 9,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          set_en,
  input  logic [IW-1:0] set_idx,
  input  logic          clr,
  output logic [N-1:0]  flags
);

  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)                                flags[i] <= 1'b0;
      else if (set_en && set_idx == IW'(i))      flags[i] <= 1'b1;
      else if (clr)                              flags[i] <= 1'b0;
    end
  end

  // R9
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set_en |=> flags == '0);

  // R9
  set_sticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_en |=> flags[$past(set_idx)]);

endmodule

// File: rtl/symbol_pair_rx.sv
module symbol_pair_rx
  import lsd_pkg::*;
#(
  parameter int IDLE_PAIRS  = 2,
  parameter int SUPER_PAIRS = 8,
  parameter int RUN_PAIRS   = 8,
  parameter int NOISE_PAIRS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [4:0]        in_sym0,
  input  logic [4:0]        in_sym1,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [3:0]        out_nib0,
  output logic [3:0]        out_nib1,
  output logic [1:0]        out_ctl,
  output logic [1:0]        out_viol,
  output logic [3:0]        line_state,
  output logic [NUM_LS-1:0] cond_flags,
  input  logic              flags_clr
);

  localparam int LANES = 2;

  logic [4:0] lane_code [LANES];
  dsym_t      lane_dec  [LANES];
  logic       acc;
  lstate_e    st, nxt;
  logic       entered;

  assign lane_code[0] = in_sym0;
  assign lane_code[1] = in_sym1;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    sym5_decode u_dec (.code(lane_code[l]), .dec(lane_dec[l]));
  end

  assign in_ready = !out_valid || out_ready;
  assign acc      = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_nib0  <= '0;
      out_nib1  <= '0;
      out_ctl   <= '0;
      out_viol  <= '0;
    end else begin
      if (acc) begin
        out_valid <= 1'b1;
        out_nib0  <= lane_dec[0].nib;
        out_nib1  <= lane_dec[1].nib;
        out_ctl   <= {lane_dec[1].ctl,  lane_dec[0].ctl};
        out_viol  <= {lane_dec[1].viol, lane_dec[0].viol};
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  line_state_tracker #(
    .IDLE_PAIRS(IDLE_PAIRS), .SUPER_PAIRS(SUPER_PAIRS),
    .RUN_PAIRS(RUN_PAIRS), .NOISE_PAIRS(NOISE_PAIRS)
  ) u_track (
    .clk(clk), .rst_n(rst_n), .acc(acc),
    .k0(lane_dec[0].kind), .k1(lane_dec[1].kind),
    .st(st), .nxt(nxt), .entered(entered)
  );

  sticky_flags #(.N(NUM_LS)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_en(entered), .set_idx(nxt),
    .clr(flags_clr), .flags(cond_flags)
  );

  assign line_state = st;

  // R10
  stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable({out_nib0, out_nib1, out_ctl, out_viol}));

  // R3
  viol_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_viol[0] |-> out_nib0 == 4'h2 && out_ctl[0]);

  // R10
  accept_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> out_valid);

endmodule

// File: tb/test_symbol_pair_rx.sv
module test_symbol_pair_rx;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [4:0] in_sym0 = '0;
  logic [4:0] in_sym1 = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [3:0] out_nib0, out_nib1;
  logic [1:0] out_ctl, out_viol;
  logic [3:0] line_state;
  logic [8:0] cond_flags;
  logic       flags_clr = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  symbol_pair_rx i_symbol_pair_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sym0(in_sym0), .in_sym1(in_sym1), .out_valid(out_valid), .out_ready(out_ready),
    .out_nib0(out_nib0), .out_nib1(out_nib1), .out_ctl(out_ctl), .out_viol(out_viol),
    .line_state(line_state), .cond_flags(cond_flags), .flags_clr(flags_clr)
  );

  typedef struct {
    logic [3:0] n0, n1;
    logic [1:0] ctl, viol;
    int         st;
    logic [8:0] flg;
    string      tag;
  } item_t;

  item_t q[$];
  int n_chk = 0;
  int n_fail = 0;
  bit bp_en = 1'b0;
  int cyc = 0;

  // model state
  int m_st = 0;
  logic [8:0] m_flg = '0;
  int r_idle = 0, r_q = 0, r_h = 0, r_hq = 0, r_v = 0;

  localparam logic [4:0] C_I = 5'b11111, C_H = 5'b00100, C_Q = 5'b00000,
                         C_J = 5'b11000, C_K = 5'b10001, C_T = 5'b01101,
                         C_R = 5'b00111, C_S = 5'b11001;

  // kinds: 0 data 1 idle 2 halt 3 quiet 4 J 5 K 6 T 7 R 8 S 9 violation
  function automatic void ref_dec(input logic [4:0] c, output logic [3:0] n,
                                  output int kind);
    kind = 0;
    case (c)
      5'b11110: n = 4'h0;  5'b01001: n = 4'h1;  5'b10100: n = 4'h2;  5'b10101: n = 4'h3;
      5'b01010: n = 4'h4;  5'b01011: n = 4'h5;  5'b01110: n = 4'h6;  5'b01111: n = 4'h7;
      5'b10010: n = 4'h8;  5'b10011: n = 4'h9;  5'b10110: n = 4'hA;  5'b10111: n = 4'hB;
      5'b11010: n = 4'hC;  5'b11011: n = 4'hD;  5'b11100: n = 4'hE;  5'b11101: n = 4'hF;
      5'b11111: begin n = 4'hA; kind = 1; end
      5'b00100: begin n = 4'h1; kind = 2; end
      5'b00000: begin n = 4'h2; kind = 3; end
      5'b11000: begin n = 4'hD; kind = 4; end
      5'b10001: begin n = 4'hD; kind = 5; end
      5'b01101: begin n = 4'h5; kind = 6; end
      5'b00111: begin n = 4'h6; kind = 7; end
      5'b11001: begin n = 4'h7; kind = 8; end
      default:  begin n = 4'h2; kind = 9; end
    endcase
  endfunction

  function automatic int bump(input int v, input bit m, input int lim);
    if (!m) return 0;
    return (v >= lim) ? lim : v + 1;
  endfunction

  task automatic send(input logic [4:0] a, input logic [4:0] b, input bit clr,
                      input string tag);
    item_t it;
    int ka, kb, nx;
    bit frame_a, frame_b;
    ref_dec(a, it.n0, ka);
    ref_dec(b, it.n1, kb);
    it.ctl  = {kb != 0, ka != 0};
    it.viol = {kb == 9, ka == 9};
    r_idle = bump(r_idle, ka == 1 && kb == 1, 8);
    r_q    = bump(r_q,    ka == 3 && kb == 3, 8);
    r_h    = bump(r_h,    ka == 2 && kb == 2, 8);
    r_hq   = bump(r_hq,   ka == 2 && kb == 3, 8);
    r_v    = bump(r_v,    ka == 9 || kb == 9, 4);
    frame_a = (ka == 0) || (ka >= 6 && ka <= 8);
    frame_b = (kb == 0) || (kb >= 6 && kb <= 8);
    if (ka == 4 && kb == 5)                    nx = 2;
    else if (m_st == 2 && frame_a && frame_b)  nx = 2;
    else if (r_idle >= 8)                      nx = 4;
    else if (r_idle >= 2)                      nx = 3;
    else if (r_q == 8)                         nx = 5;
    else if (r_h == 8)                         nx = 6;
    else if (r_hq == 8)                        nx = 7;
    else if (r_v == 4)                         nx = 8;
    else                                       nx = 1;
    if (clr) m_flg = '0;
    if (nx != m_st) m_flg[nx] = 1'b1;
    m_st = nx;
    it.st = nx;
    it.flg = m_flg;
    it.tag = tag;
    q.push_back(it);
    @(negedge clk);
    in_sym0 = a; in_sym1 = b; in_valid = 1'b1; flags_clr = clr;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    flags_clr = 1'b0;
  endtask

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic drain();
    int guard = 0;
    while ((q.size() != 0 || out_valid) && guard < 1000) begin
      @(negedge clk);
      guard++;
    end
    repeat (2) @(negedge clk);
  endtask

  // back-pressure pattern, changed away from both clock edges
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #2;
    out_ready = !bp_en || (cyc % 3 != 0);
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (q.size() == 0) begin
        check(1'b0, "R10 unexpected output", 1, 0);
      end else begin
        item_t e;
        e = q.pop_front();
        check({out_nib0, out_nib1} == {e.n0, e.n1}, {e.tag, " nibbles"},
              {out_nib0, out_nib1}, {e.n0, e.n1});
        check({out_ctl, out_viol} == {e.ctl, e.viol}, {e.tag, " markers"},
              {out_ctl, out_viol}, {e.ctl, e.viol});
        check(int'(line_state) == e.st, {e.tag, " line_state"}, line_state, e.st);
        check(cond_flags == e.flg, {e.tag, " cond_flags"}, cond_flags, e.flg);
      end
    end
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [4:0] dat [16];
    logic [4:0] bad [8];
    dat = '{5'b11110, 5'b01001, 5'b10100, 5'b10101, 5'b01010, 5'b01011, 5'b01110, 5'b01111,
            5'b10010, 5'b10011, 5'b10110, 5'b10111, 5'b11010, 5'b11011, 5'b11100, 5'b11101};
    bad = '{5'b00001, 5'b00010, 5'b00011, 5'b00101, 5'b00110, 5'b01000, 5'b01100, 5'b10000};

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11
    check(out_valid == 1'b0, "R11 out_valid", out_valid, 0);
    check(in_ready == 1'b1, "R11 in_ready", in_ready, 1);
    check(line_state == 4'd0, "R11 line_state", line_state, 0);
    check(cond_flags == '0, "R11 cond_flags", cond_flags, 0);

    // R1 all data codes, R5 non-frame data outside active gives unknown
    for (int i = 0; i < 16; i++) send(dat[i], dat[15 - i], 1'b0, "R1");
    // R2 control codes
    send(C_I, C_H, 1'b0, "R2");
    send(C_T, C_R, 1'b0, "R2");
    send(C_S, C_Q, 1'b0, "R2");
    send(C_J, C_K, 1'b0, "R2");
    // R4 active held by data, T, R, S
    send(dat[3], dat[9], 1'b0, "R4");
    send(C_T, C_R, 1'b0, "R4");
    send(C_S, C_S, 1'b0, "R4");
    // R5 violation in active leaves it
    send(dat[1], bad[0], 1'b0, "R5");
    send(C_J, C_K, 1'b0, "R4");
    send(dat[2], C_I, 1'b0, "R5");
    // R3 and R8 violation codes, four violation pairs
    for (int i = 0; i < 4; i++) send(bad[2 * i], bad[2 * i + 1], 1'b0, "R8");
    send(bad[3], dat[0], 1'b0, "R8");
    // R6 idle runs
    send(C_I, C_I, 1'b0, "R6");
    send(C_Q, C_Q, 1'b0, "R6");
    for (int i = 0; i < 10; i++) send(C_I, C_I, 1'b0, "R6");
    // R7 quiet, halt, halt-quiet runs and a broken run
    for (int i = 0; i < 9; i++) send(C_Q, C_Q, 1'b0, "R7");
    for (int i = 0; i < 8; i++) send(C_H, C_H, 1'b0, "R7");
    for (int i = 0; i < 8; i++) send(C_H, C_Q, 1'b0, "R7");
    for (int i = 0; i < 5; i++) send(C_Q, C_Q, 1'b0, "R7");
    send(dat[4], dat[4], 1'b0, "R7");
    for (int i = 0; i < 7; i++) send(C_Q, C_Q, 1'b0, "R7");
    drain();

    // R9 set and clear on the same edge
    send(C_J, C_K, 1'b1, "R9");
    drain();
    // R9 clear alone
    @(negedge clk);
    flags_clr = 1'b1;
    @(posedge clk);
    #1;
    flags_clr = 1'b0;
    m_flg = '0;
    @(negedge clk);
    check(cond_flags == '0, "R9 clear alone", cond_flags, 0);
    check(line_state == 4'd2, "R9 state kept by clear", line_state, 2);

    // R10 back-pressure mix
    bp_en = 1'b1;
    for (int i = 0; i < 12; i++) send(dat[i], dat[(i + 5) % 16], 1'b0, "R10");
    for (int i = 0; i < 3; i++) send(C_I, C_I, 1'b0, "R10");
    for (int i = 0; i < 4; i++) send(bad[i], bad[7 - i], 1'b0, "R10");
    drain();
    bp_en = 1'b0;
    check(q.size() == 0, "R10 queue drained", q.size(), 0);

    finish_run();
  end

endmodule